// File: doc/BRIEF.md
# Power-Good Strap Capture and Start-Up Sequencer

This block decides when a clock synthesizer may trust its configuration straps and then brings it up in order. After reset it waits, with everything off, for an active-low power-good strobe. The first time that strobe is seen low, a glitch-rejection interval starts. The interval lets a ramping supply settle. At its end, the block latches the mode strap, the two frequency-select straps and the output-current strap exactly once. In the same edge it turns the VCO on. After a further settling interval it enables the clock outputs.

The mode strap is a three-level pin. It reaches the block as two comparator bits, one saying the pin is below the low threshold and one saying it is above the high threshold. Neither bit set means the middle level, which selects test mode. The power-good pin passes through a reset-to-inactive synchronizer. Once it has been seen low, the block pays no further attention to it until the next reset. Both intervals are parameters in timer-clock cycles. The glitch-rejection default is a quarter of a millisecond at the nominal timer rate.

Top module: `strap_seq_top`

## Requirements
- R1: During and right after the synchronous reset, the outputs take these values: `seq_state`=0, `straps_valid`=0, `vco_en`=0, `out_en`=0, `strap_code`=0, `s2_level`=0, `mult0_q`=0, `test_mode`=0.
- R2: While `pwr_good_n` stays high after reset, the sequencer remains in state 0 (off) and nothing is latched.
- R3: A low on `pwr_good_n` passes through a SYNC_STAGES-flop synchronizer. Counting the first clock edge that samples the low as edge 1, `seq_state` becomes 1 (waiting) after edge SYNC_STAGES+1.
- R4: The straps are latched, and `straps_valid` rises, GLITCH_CYCLES edges after state 1 is entered. Before that edge, `straps_valid` and `vco_en` are both 0.
- R5: The latched values follow a fixed encoding. `strap_code` bit 2 is 1 only when the mode strap was high. Bit 1 holds the S1 strap and bit 0 holds the S0 strap. `mult0_q` holds the current-multiplier strap. Every latched value is the one present at the latch edge.
- R6: The three-level decode works as follows. `s2_below_lo`=1 with `s2_above_hi`=0 gives low, with `s2_level`=0. `s2_above_hi`=1 with `s2_below_lo`=0 gives high, with `s2_level`=2. Both bits 0, or both bits 1, give mid, with `s2_level`=1 and `test_mode`=1. `test_mode` is 0 for the other levels.
- R7: `vco_en` rises in the same edge as the latch, and `seq_state` becomes 2 in that edge. `out_en` rises, with `seq_state`=3, LOCK_CYCLES edges later. `out_en` is never 1 while `vco_en` is 0.
- R8: Once the low has been seen, `pwr_good_n` is ignored. A return to high during the wait does not stop the sequence. After the latch, changes on `pwr_good_n` or on any strap input leave every output unchanged until reset.
- R9: A new reset clears the latch, and the block captures fresh strap values on the next power-good low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_n | input | 1 | Active-low power-good strobe, asynchronous |
| s2_below_lo | input | 1 | Mode strap comparator: below low threshold |
| s2_above_hi | input | 1 | Mode strap comparator: above high threshold |
| s1_pin | input | 1 | Frequency-select strap, upper bit |
| s0_pin | input | 1 | Frequency-select strap, lower bit |
| mult0_pin | input | 1 | Output-current multiplier strap |
| seq_state | output | 2 | 0 off, 1 waiting, 2 VCO on, 3 outputs on |
| straps_valid | output | 1 | Latched straps are valid |
| strap_code | output | 3 | {mode high, S1, S0} as latched |
| s2_level | output | 2 | Latched mode level: 0 low, 1 mid, 2 high |
| mult0_q | output | 1 | Latched current-multiplier strap |
| test_mode | output | 1 | Mode strap was mid at latch time |
| vco_en | output | 1 | VCO enable |
| out_en | output | 1 | Clock output enable |

## Verification
The strap latch and the VCO enable share one edge. The power-good pin may also return high in that same edge, and that change must be ignored. The bench drives each level of the mode strap and random frequency and current straps. It counts edges from the power-good low and samples on both sides of the latch edge. In some trials it lets the strobe bounce high during the wait, and after the latch it scrambles every input. It judges the results by requiring valid, the VCO enable and the expected codes to appear together at the computed edge, and by requiring all of them to hold afterwards.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_VCO  = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  function automatic lvl_e decode_level(input logic below_lo, input logic above_hi);
    if (below_lo && !above_hi)      return LVL_LOW;
    else if (above_hi && !below_lo) return LVL_HIGH;
    else                            return LVL_MID;
  endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic pg_low
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign pg_low = ~chain[STAGES-1];

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import strap_seq_pkg::*;
#(
  parameter int GLITCH_CYCLES = 3579,
  parameter int LOCK_CYCLES   = 1431
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_low,
  output seq_state_e state,
  output logic       capture,
  output logic       vco_en,
  output logic       out_en
);

  localparam int MAXC = (GLITCH_CYCLES > LOCK_CYCLES) ? GLITCH_CYCLES : LOCK_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e      state_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    state_d = state;
    cnt_d   = cnt_q;
    capture = 1'b0;
    case (state)
      SEQ_OFF: begin
        if (pg_low) begin
          state_d = SEQ_WAIT;
          cnt_d   = CW'(GLITCH_CYCLES - 1);
        end
      end
      SEQ_WAIT: begin
        if (cnt_q == '0) begin
          state_d = SEQ_VCO;
          cnt_d   = CW'(LOCK_CYCLES - 1);
          capture = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SEQ_VCO: begin
        if (cnt_q == '0) state_d = SEQ_RUN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_OFF;
      cnt_q  <= '0;
      vco_en <= 1'b0;
      out_en <= 1'b0;
    end else begin
      state  <= state_d;
      cnt_q  <= cnt_d;
      vco_en <= (state_d == SEQ_VCO) || (state_d == SEQ_RUN);
      out_en <= (state_d == SEQ_RUN);
    end
  end

  AST_OUT_NEEDS_VCO: assert property (@(posedge clk) disable iff (rst)
    out_en |-> vco_en); // R7
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_OFF && !pg_low) |=> (state == SEQ_OFF)); // R2
  AST_WAIT_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_WAIT) |=> (state == SEQ_WAIT || state == SEQ_VCO)); // R8
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_RUN) |=> (state == SEQ_RUN && out_en)); // R8

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic       below_lo,
  input  logic       above_hi,
  input  logic       s1,
  input  logic       s0,
  input  logic       mult0,
  output logic       valid,
  output logic [2:0] code,
  output lvl_e       level,
  output logic       mult0_q,
  output logic       test_mode
);

  lvl_e lvl_now;
  assign lvl_now = decode_level(below_lo, above_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      code      <= 3'b000;
      level     <= LVL_LOW;
      mult0_q   <= 1'b0;
      test_mode <= 1'b0;
    end else if (capture && !valid) begin
      valid     <= 1'b1;
      code      <= {(lvl_now == LVL_HIGH), s1, s0};
      level     <= lvl_now;
      mult0_q   <= mult0;
      test_mode <= (lvl_now == LVL_MID);
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid); // R8
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid |=> ($stable(code) && $stable(level) && $stable(mult0_q) && $stable(test_mode))); // R8

endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
  import strap_seq_pkg::*;
#(
  parameter int TIMER_HZ      = 14_318_180,
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = TIMER_HZ / 4000,
  parameter int LOCK_CYCLES   = TIMER_HZ / 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good_n,
  input  logic       s2_below_lo,
  input  logic       s2_above_hi,
  input  logic       s1_pin,
  input  logic       s0_pin,
  input  logic       mult0_pin,
  output logic [1:0] seq_state,
  output logic       straps_valid,
  output logic [2:0] strap_code,
  output logic [1:0] s2_level,
  output logic       mult0_q,
  output logic       test_mode,
  output logic       vco_en,
  output logic       out_en
);

  logic       pg_low;
  logic       capture;
  seq_state_e state;
  lvl_e       level;

  pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_n  (pwr_good_n),
    .pg_low (pg_low)
  );

  seq_fsm #(
    .GLITCH_CYCLES (GLITCH_CYCLES),
    .LOCK_CYCLES   (LOCK_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .pg_low  (pg_low),
    .state   (state),
    .capture (capture),
    .vco_en  (vco_en),
    .out_en  (out_en)
  );

  strap_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .below_lo  (s2_below_lo),
    .above_hi  (s2_above_hi),
    .s1        (s1_pin),
    .s0        (s0_pin),
    .mult0     (mult0_pin),
    .valid     (straps_valid),
    .code      (strap_code),
    .level     (level),
    .mult0_q   (mult0_q),
    .test_mode (test_mode)
  );

  assign seq_state = state;
  assign s2_level  = level;

  AST_NO_VCO_EARLY: assert property (@(posedge clk) disable iff (rst)
    !straps_valid |-> !vco_en); // R4
  AST_VCO_WITH_LATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(straps_valid) |-> vco_en); // R7

endmodule

// File: tb/strap_seq_top_tb.sv
module strap_seq_top_tb;

  localparam int G = 20;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_good_n = 1'b1;
  logic       s2_below_lo = 1'b1, s2_above_hi = 1'b0;
  logic       s1_pin = 1'b0, s0_pin = 1'b0, mult0_pin = 1'b0;
  logic [1:0] seq_state;
  logic       straps_valid;
  logic [2:0] strap_code;
  logic [1:0] s2_level;
  logic       mult0_q, test_mode, vco_en, out_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  strap_seq_top #(
    .SYNC_STAGES   (2),
    .GLITCH_CYCLES (G),
    .LOCK_CYCLES   (L)
  ) u_dut (
    .clk (clk), .rst (rst), .pwr_good_n (pwr_good_n),
    .s2_below_lo (s2_below_lo), .s2_above_hi (s2_above_hi),
    .s1_pin (s1_pin), .s0_pin (s0_pin), .mult0_pin (mult0_pin),
    .seq_state (seq_state), .straps_valid (straps_valid),
    .strap_code (strap_code), .s2_level (s2_level),
    .mult0_q (mult0_q), .test_mode (test_mode),
    .vco_en (vco_en), .out_en (out_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0 low, 1 mid (neither), 2 high, 3 mid (both bits)
  function automatic int exp_level(input int sel);
    return (sel == 0) ? 0 : (sel == 2) ? 2 : 1;
  endfunction

  function automatic int exp_code(input int sel, input bit a, input bit b);
    return ((sel == 2) ? 4 : 0) + (a ? 2 : 0) + (b ? 1 : 0);
  endfunction

  task automatic set_s2(input int sel);
    s2_below_lo = (sel == 0) || (sel == 3);
    s2_above_hi = (sel == 2) || (sel == 3);
  endtask

  task automatic trial(input int sel, input bit a, input bit b, input bit m, input bit bounce);
    int idle;
    logic [2:0] code_keep;
    @(negedge clk);
    rst = 1'b1; pwr_good_n = 1'b1;
    set_s2(sel); s1_pin = a; s0_pin = b; mult0_pin = m;
    step(3);
    chk(seq_state == 0 && !straps_valid && !vco_en && !out_en && strap_code == 0 &&
        s2_level == 0 && !mult0_q && !test_mode, "R1 reset state", seq_state, 0);
    rst = 1'b0;
    step(1);
    chk(seq_state == 0 && !straps_valid && !vco_en, "R1 after release", seq_state, 0);
    idle = 5 + int'($urandom_range(0, 25));
    step(idle);
    chk(seq_state == 0 && !straps_valid, "R2 idle while high", seq_state, 0);
    pwr_good_n = 1'b0;
    step(3);
    chk(seq_state == 1, "R3 waiting state", seq_state, 1);
    if (bounce) pwr_good_n = 1'b1;
    step(G - 1);
    chk(!straps_valid && !vco_en, "R4 not valid before wait ends", straps_valid, 0);
    chk(seq_state == 1, "R8 wait continues", seq_state, 1);
    // same edge as latch: pin released
    pwr_good_n = 1'b1;
    step(1);
    chk(straps_valid == 1, "R4 valid at latch edge", straps_valid, 1);
    chk(strap_code == exp_code(sel, a, b), "R5 strap code", strap_code, exp_code(sel, a, b));
    chk(mult0_q == m, "R5 mult0", mult0_q, m);
    chk(s2_level == exp_level(sel), "R6 level", s2_level, exp_level(sel));
    chk(test_mode == (exp_level(sel) == 1), "R6 test mode", test_mode, exp_level(sel) == 1);
    chk(vco_en && !out_en && seq_state == 2, "R7 vco on with latch", seq_state, 2);
    step(L - 1);
    chk(!out_en && vco_en, "R7 outputs still off", out_en, 0);
    step(1);
    chk(out_en && vco_en && seq_state == 3, "R7 outputs on", seq_state, 3);
    code_keep = strap_code;
    for (int i = 0; i < 10; i++) begin
      pwr_good_n = 1'($urandom); set_s2(int'($urandom_range(0, 3)));
      s1_pin = 1'($urandom); s0_pin = 1'($urandom); mult0_pin = 1'($urandom);
      step(1);
    end
    chk(strap_code == code_keep && mult0_q == m && s2_level == exp_level(sel) &&
        straps_valid && out_en && vco_en && seq_state == 3,
        "R8 inputs ignored after latch", strap_code, code_keep);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    step(2);
    trial(0, 1'b0, 1'b1, 1'b0, 1'b0);
    trial(1, 1'b1, 1'b0, 1'b1, 1'b0);
    trial(2, 1'b1, 1'b1, 1'b1, 1'b1);
    trial(3, 1'b0, 1'b0, 1'b0, 1'b1);
    // R9: repeated resets must capture fresh values each time
    for (int t = 0; t < 14; t++) begin
      trial(int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule